// File: doc/BRIEF.md
# Banished-Line Reconstitution Counter

This block sits beside a small array of shared-cache lines and decides when a line that was pushed out of the private caches may be cached privately again. A line is pushed out because it is both shared and written. The broadcast invalidation that pushes it out also arms a 2-bit saturating counter for that line, loaded with 2. Every write to the pushed-out line raises the counter, stopping at 3. A shared period timer lowers the counter of every pushed-out line once per period, stopping at 0. A line that shows no write activity therefore drifts down to 0. The first read after that returns the line to private caching.

On that qualifying read, the block produces a one-cycle reconstitution pulse with the line index and the reading core. It also produces a matching pulse telling the shared cache to clear the line's shared and written bits and to hand the exclusivity token to that core. The period is set at run time:
- 0 or 1 decrements every cycle, so reconstitution comes almost at once.
- Any value from 2 up to one below all-ones decrements once per that many cycles.
- The all-ones value stops decay entirely, so a pushed-out line is never returned.

Each line has two states:
- `LN_CACHEABLE`: the line may live in private caches.
- `LN_BANISHED`: the line lives only in the shared cache.

The transitions are:
- Invalidate moves `LN_CACHEABLE` to `LN_BANISHED`.
- Invalidate while in `LN_BANISHED` reloads the counter to 2 and stays in `LN_BANISHED`.
- A qualifying read moves `LN_BANISHED` back to `LN_CACHEABLE`.

A line can go around this loop any number of times.

Top module: `recon_ctl`

## Requirements
- R1: After reset no line is banished (`banished_o` all zero), and `recon_valid_o` and `clr_share_o` are low.
- R2: An invalidate for line i sets `banished_o[i]` at the next clock edge and loads the line's counter with 2, whatever the line's prior state.
- R3: A write to a banished line raises its counter by one, saturating at 3.
- R4: With `period_i` = N where 2 <= N < all-ones, the timer lowers every banished line's counter once every N cycles, saturating at 0. The first decrement comes at the Nth clock edge after reset.
- R5: With `period_i` equal to 0 or 1, a decrement occurs at every clock edge.
- R6: With `period_i` all ones, no decrement occurs and the timer stays cleared, so a line banished under that setting is never reconstituted.
- R7: A read to a banished line whose counter is 0 clears `banished_o` for that line at the next edge. In the same cycle it raises `recon_valid_o` and `clr_share_o` for one cycle, with `recon_idx_o` equal to the read index and `recon_core_o` equal to the reading core.
- R8: A read to a banished line whose counter is nonzero, and reads or writes to a line that is not banished, change no output.
- R9: A write and a timer decrement on the same banished line in the same cycle cancel, leaving the counter unchanged.
- R10: A write to the same line in the same cycle as an otherwise qualifying read blocks reconstitution; the write then raises the counter.
- R11: An invalidate has priority over a same-cycle read or write to the same line. A reconstituted line can be banished and reconstituted again repeatedly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inval_valid_i | input | 1 | Broadcast invalidate event for one line |
| inval_idx_i | input | $clog2(NLINES) | Line being invalidated |
| wr_valid_i | input | 1 | Write to a line |
| wr_idx_i | input | $clog2(NLINES) | Line being written |
| rd_valid_i | input | 1 | Read to a line |
| rd_idx_i | input | $clog2(NLINES) | Line being read |
| rd_core_i | input | $clog2(NCORES) | Core issuing the read |
| period_i | input | PW | Decay period; all ones means no decay |
| banished_o | output | NLINES | Per-line banished flag |
| recon_valid_o | output | 1 | One-cycle reconstitution pulse |
| recon_idx_o | output | $clog2(NLINES) | Line reconstituted |
| recon_core_o | output | $clog2(NCORES) | Core that receives the token |
| clr_share_o | output | 1 | Clear shared and written bits of `recon_idx_o` |

## Verification
The assertions check four properties on every cycle:
- A line becomes banished only after an invalidate for that index.
- A line leaves the banished state only together with a reconstitution pulse naming it.
- Every pulse follows a read of that very line by the named core, on a line that was banished.
- The clear pulse always coincides with the reconstitution pulse.

The counter arithmetic is not visible at the ports, so only the bench's scenarios can show it. This covers the load value of 2, saturation at 3 and 0, the write/decrement cancellation, the exact decay period for each setting, and the blocking effect of a same-cycle write. The bench shows these through the cycle at which each reconstitution becomes possible.

// File: rtl/recon_pkg.sv
package recon_pkg;

    typedef enum logic {
        LN_CACHEABLE = 1'b0,
        LN_BANISHED  = 1'b1
    } line_state_e;

    localparam int CNT_W = 2;
    localparam logic [CNT_W-1:0] CNT_LOAD = 2'd2;
    localparam logic [CNT_W-1:0] CNT_MAX  = 2'd3;
    localparam logic [CNT_W-1:0] CNT_MIN  = 2'd0;

endpackage

// File: rtl/recon_period_timer.sv
module recon_period_timer #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_i,
    output logic          tick_o
);

    logic [PW-1:0] cnt_q;
    logic          no_decay;

    assign no_decay = &period_i;

    always_comb begin
        if (no_decay) begin
            tick_o = 1'b0;
        end else if (period_i <= PW'(1)) begin
            tick_o = 1'b1;
        end else begin
            tick_o = (cnt_q >= (period_i - PW'(1)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (no_decay || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PW'(1);
        end
    end

endmodule

// File: rtl/recon_line.sv
module recon_line
    import recon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inval_hit_i,
    input  logic wr_hit_i,
    input  logic rd_hit_i,
    input  logic tick_i,
    output logic banished_o,
    output logic fire_o
);

    line_state_e      st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             qualify;

    // read reaches a quiet, fully decayed banished line with no competing event
    assign qualify = rd_hit_i && !wr_hit_i && !inval_hit_i && (cnt_q == CNT_MIN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= LN_CACHEABLE;
            cnt_q <= CNT_MIN;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            LN_CACHEABLE: begin
                if (inval_hit_i) begin
                    st_n  = LN_BANISHED;
                    cnt_n = CNT_LOAD;
                end
            end
            LN_BANISHED: begin
                if (inval_hit_i) begin
                    cnt_n = CNT_LOAD;
                end else if (qualify) begin
                    st_n = LN_CACHEABLE;
                end else if (wr_hit_i && !tick_i) begin
                    cnt_n = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 2'd1;
                end else if (tick_i && !wr_hit_i) begin
                    cnt_n = (cnt_q == CNT_MIN) ? cnt_q : cnt_q - 2'd1;
                end
            end
            default: begin
                st_n  = LN_CACHEABLE;
                cnt_n = CNT_MIN;
            end
        endcase
    end

    always_comb begin
        banished_o = (st_q == LN_BANISHED);
        fire_o     = (st_q == LN_BANISHED) && qualify;
    end

endmodule

// File: rtl/recon_ctl.sv
module recon_ctl #(
    parameter int NLINES = 8,
    parameter int NCORES = 4,
    parameter int PW     = 8,
    localparam int IW    = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int CW    = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval_valid_i,
    input  logic [IW-1:0]     inval_idx_i,
    input  logic              wr_valid_i,
    input  logic [IW-1:0]     wr_idx_i,
    input  logic              rd_valid_i,
    input  logic [IW-1:0]     rd_idx_i,
    input  logic [CW-1:0]     rd_core_i,
    input  logic [PW-1:0]     period_i,
    output logic [NLINES-1:0] banished_o,
    output logic              recon_valid_o,
    output logic [IW-1:0]     recon_idx_o,
    output logic [CW-1:0]     recon_core_o,
    output logic              clr_share_o
);

    logic              tick;
    logic [NLINES-1:0] fire;

    recon_period_timer #(.PW(PW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .tick_o   (tick)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        recon_line u_line (
            .clk         (clk),
            .rst_n       (rst_n),
            .inval_hit_i (inval_valid_i && (inval_idx_i == IW'(g))),
            .wr_hit_i    (wr_valid_i && (wr_idx_i == IW'(g))),
            .rd_hit_i    (rd_valid_i && (rd_idx_i == IW'(g))),
            .tick_i      (tick),
            .banished_o  (banished_o[g]),
            .fire_o      (fire[g])
        );
    end

    // one read per cycle, so at most one line fires
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recon_valid_o <= 1'b0;
            clr_share_o   <= 1'b0;
            recon_idx_o   <= '0;
            recon_core_o  <= '0;
        end else begin
            recon_valid_o <= |fire;
            clr_share_o   <= |fire;
            if (|fire) begin
                recon_idx_o  <= rd_idx_i;
                recon_core_o <= rd_core_i;
            end
        end
    end

endmodule

// File: rtl/recon_ctl_chk.sv
module recon_ctl_chk #(
    parameter int NLINES = 8,
    parameter int NCORES = 4,
    parameter int PW     = 8,
    localparam int IW    = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int CW    = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inval_valid_i,
    input logic [IW-1:0]     inval_idx_i,
    input logic              wr_valid_i,
    input logic [IW-1:0]     wr_idx_i,
    input logic              rd_valid_i,
    input logic [IW-1:0]     rd_idx_i,
    input logic [CW-1:0]     rd_core_i,
    input logic [PW-1:0]     period_i,
    input logic [NLINES-1:0] banished_o,
    input logic              recon_valid_o,
    input logic [IW-1:0]     recon_idx_o,
    input logic [CW-1:0]     recon_core_o,
    input logic              clr_share_o
);

    // R7: clear pulse travels with the reconstitution pulse
    p_clear_with_recon_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_share_o == recon_valid_o);

    // R7: a pulse names the line and core of the read one cycle earlier
    p_recon_from_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        recon_valid_o |-> ($past(rd_valid_i) && ($past(rd_idx_i) == recon_idx_o)
                           && ($past(rd_core_i) == recon_core_o)));

    // R8: only a banished line can be reconstituted
    p_recon_was_banished_r8: assert property (@(posedge clk) disable iff (!rst_n)
        recon_valid_o |-> ((($past(banished_o) >> recon_idx_o) & NLINES'(1)) != '0));

    // R7: the reconstituted line is cacheable again
    p_recon_line_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        recon_valid_o |-> !(((banished_o >> recon_idx_o) & NLINES'(1)) != '0));

    // R2: an invalidate always leaves its line banished
    p_inval_bans_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inval_valid_i |=> banished_o[$past(inval_idx_i)]);

    for (genvar g = 0; g < NLINES; g++) begin : g_line_chk
        // R2: a line becomes banished only through an invalidate
        p_rise_needs_inval_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(banished_o[g]) |-> $past(inval_valid_i && (inval_idx_i == IW'(g))));
        // R7: a line leaves the banished state only with a pulse naming it
        p_fall_needs_recon_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(banished_o[g]) |-> (recon_valid_o && (recon_idx_o == IW'(g))));
    end

endmodule

bind recon_ctl recon_ctl_chk #(.NLINES(NLINES), .NCORES(NCORES), .PW(PW)) i_chk (.*);

// File: tb/test_recon_ctl.sv
module test_recon_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int NL  = 8;
    localparam int NC  = 4;
    localparam int PW  = 8;
    localparam int IW  = $clog2(NL);
    localparam int CW  = $clog2(NC);
    localparam int INF = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inval_valid = 1'b0;
    logic [IW-1:0] inval_idx = '0;
    logic          wr_valid = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic          rd_valid = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic [CW-1:0] rd_core = '0;
    logic [PW-1:0] period = '0;
    logic [NL-1:0] banished;
    logic          recon_valid;
    logic [IW-1:0] recon_idx;
    logic [CW-1:0] recon_core;
    logic          clr_share;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string cur_req = "R1";

    recon_ctl #(.NLINES(NL), .NCORES(NC), .PW(PW)) i_recon_ctl (
        .clk(clk), .rst_n(rst_n),
        .inval_valid_i(inval_valid), .inval_idx_i(inval_idx),
        .wr_valid_i(wr_valid), .wr_idx_i(wr_idx),
        .rd_valid_i(rd_valid), .rd_idx_i(rd_idx), .rd_core_i(rd_core),
        .period_i(period),
        .banished_o(banished), .recon_valid_o(recon_valid),
        .recon_idx_o(recon_idx), .recon_core_o(recon_core),
        .clr_share_o(clr_share)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int m_tmr;
    bit m_ban [NL];
    int m_cnt [NL];
    bit e_rv;
    int e_idx, e_core;

    always @(posedge clk) begin : model
        bit tk, inf, ih, wh, rh;
        cycles++;
        if (!rst_n) begin
            m_tmr = 0;
            e_rv = 0; e_idx = 0; e_core = 0;
            for (int i = 0; i < NL; i++) begin m_ban[i] = 0; m_cnt[i] = 0; end
        end else begin
            inf = (int'(period) == INF);
            tk  = inf ? 0 : (int'(period) <= 1) ? 1 : (m_tmr >= int'(period) - 1);
            m_tmr = (inf || tk) ? 0 : m_tmr + 1;
            e_rv = 0;
            for (int i = 0; i < NL; i++) begin
                ih = inval_valid && (int'(inval_idx) == i);
                wh = wr_valid && (int'(wr_idx) == i);
                rh = rd_valid && (int'(rd_idx) == i);
                if (ih) begin
                    m_ban[i] = 1; m_cnt[i] = 2;
                end else if (m_ban[i]) begin
                    if (rh && !wh && m_cnt[i] == 0) begin
                        m_ban[i] = 0; e_rv = 1; e_idx = i; e_core = int'(rd_core);
                    end else if (wh && !tk) begin
                        if (m_cnt[i] < 3) m_cnt[i]++;
                    end else if (tk && !wh) begin
                        if (m_cnt[i] > 0) m_cnt[i]--;
                    end
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            for (int i = 0; i < NL; i++)
                if (banished[i] !== m_ban[i]) begin
                    miscompares++;
                    $display("FAIL %s: banished[%0d] actual %0b expected %0b", cur_req, i, banished[i], m_ban[i]);
                end
            if (recon_valid !== e_rv || clr_share !== e_rv) begin
                miscompares++;
                $display("FAIL %s: recon/clr actual %0b/%0b expected %0b", cur_req, recon_valid, clr_share, e_rv);
            end else if (e_rv && (int'(recon_idx) != e_idx || int'(recon_core) != e_core)) begin
                miscompares++;
                $display("FAIL %s: recon idx/core actual %0d/%0d expected %0d/%0d", cur_req, recon_idx, recon_core, e_idx, e_core);
            end
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic cyc(input bit iv, input int ii, input bit wv, input int wi,
                       input bit rv, input int ri, input int rc);
        @(negedge clk); #1;
        inval_valid = iv; inval_idx = IW'(ii);
        wr_valid = wv; wr_idx = IW'(wi);
        rd_valid = rv; rd_idx = IW'(ri); rd_core = CW'(rc);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #2;
        chk(|banished, 1'b0, "R1 banished after reset");
        chk(recon_valid, 1'b0, "R1 recon after reset");

        // R4: period 4, reads every cycle until reconstituted
        cur_req = "R4"; period = PW'(4);
        cyc(1, 3, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 3, 1);
        for (int k = 0; k < 20; k++) cyc(0, 0, 0, 0, 1, 3, 2);
        idle(2);

        // R3: writes saturate, decay from 3 takes longer
        cur_req = "R3";
        cyc(1, 1, 0, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) cyc(0, 0, 1, 1, 0, 0, 0);
        for (int k = 0; k < 20; k++) cyc(0, 0, 0, 0, 1, 1, 3);

        // R5: period 0, near-immediate reconstitution
        cur_req = "R5"; period = PW'(0);
        cyc(1, 2, 0, 0, 0, 0, 0);
        idle(4);
        cyc(0, 0, 0, 0, 1, 2, 3);
        @(negedge clk); #2;
        chk(recon_valid, 1'b1, "R7 pulse after quiet decay");
        chk(banished[2], 1'b0, "R7 line cacheable");
        chk(recon_idx == IW'(2) && recon_core == CW'(3), 1'b1, "R7 idx/core");

        // R10: write in the same cycle blocks reconstitution
        cur_req = "R10";
        cyc(1, 2, 0, 0, 0, 0, 0);
        idle(4);
        cyc(0, 0, 1, 2, 1, 2, 1);
        @(negedge clk); #2;
        chk(recon_valid, 1'b0, "R10 no pulse");
        chk(banished[2], 1'b1, "R10 still banished");
        idle(4);
        cyc(0, 0, 0, 0, 1, 2, 1);
        idle(2);

        // R9: period 1, write each cycle cancels decay
        cur_req = "R9"; period = PW'(1);
        cyc(1, 4, 0, 0, 0, 0, 0);
        for (int k = 0; k < 10; k++) cyc(0, 0, 1, 4, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 4, 0);
        @(negedge clk); #2;
        chk(recon_valid, 1'b0, "R9 counter held at 2");
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 1, 4, 0);

        // R11: invalidate beats same-cycle read; repeated loops
        cur_req = "R11"; period = PW'(0);
        for (int r = 0; r < 3; r++) begin
            cyc(1, 6, 0, 0, 0, 0, 0);
            idle(3);
            cyc(1, 6, 0, 0, 1, 6, 2);
            @(negedge clk); #2;
            chk(recon_valid, 1'b0, "R11 invalidate wins");
            idle(3);
            cyc(0, 0, 0, 0, 1, 6, 2);
            @(negedge clk); #2;
            chk(recon_valid, 1'b1, "R11 re-reconstituted");
        end

        // R8: traffic to cacheable lines and early reads do nothing
        cur_req = "R8";
        for (int k = 0; k < 6; k++) cyc(0, 0, 1, k, 1, k, 1);
        @(negedge clk); #2;
        chk(recon_valid | (|banished), 1'b0, "R8 cacheable traffic ignored");

        // R6: no decay under the all-ones period
        cur_req = "R6"; period = PW'(INF);
        cyc(1, 5, 0, 0, 0, 0, 0);
        for (int k = 0; k < 300; k++) cyc(0, 0, 0, 0, 1, 5, 2);
        @(negedge clk); #2;
        chk(banished[5], 1'b1, "R6 never reconstituted");
        chk(recon_valid, 1'b0, "R8 read with nonzero counter ignored");

        // mixed traffic covering R2 R3 R4 R9 R10
        cur_req = "R2 mixed";
        for (int k = 0; k < 3000; k++) begin
            if (k % 500 == 0) begin
                case ((k / 500) % 4)
                    0: period = PW'(3);
                    1: period = PW'(0);
                    2: period = PW'(INF);
                    default: period = PW'(1);
                endcase
            end
            cyc(($urandom % 8) == 0, $urandom % NL,
                ($urandom % 4) == 0, $urandom % NL,
                ($urandom % 2) == 0, $urandom % NL, $urandom % NC);
        end
        idle(3);
        finish_run();
    end

endmodule